// File: doc/BRIEF.md
# Channel Scan Sequencer

This block keeps track of which of sixteen receive channels a radio receiver is listening on. It walks the channels in a fixed interleaved order, beginning at a configured home channel. It tells an external controller about each step by raising a one-cycle pulse while the synthesizer-enable window is open. The controller counts those pulses and retunes the synthesizer while the window is closed. The block's own channel value takes the accumulated target at the next rising edge of the window.

Once a synchronisation indication arrives, the block enters one of two synced modes, chosen by a mode select input. In lock mode it stays on the current channel. In normal mode it keeps stepping. A sync-loss hold timer, measured in ticks of a slow timebase (one tick per minute in a product), decides when a persistent loss of sync sends the block back to scanning. If a set number of complete scans find nothing, the block rests in an idle state for a set number of ticks and then scans again.

Top module: `chan_scan_seq`

## Requirements
- R1: Scan position p (0 to 15) maps to channel 2p for p below 8 and to 31-2p otherwise. Stepping moves one position, and position 15 wraps to position 0.
- R2: While stepping is allowed and the window is high, each run of DWELL_CYC window-high clock cycles advances the target by one position and produces exactly one `chg_pulse` that is high for one clock.
- R3: `chg_pulse` is never raised unless `syn_win` was high in the previous cycle. With the window held low, no pulse appears.
- R4: `cur_ch` changes only at a rising edge of `syn_win`, where it takes the accumulated target, or at a rising edge of `run_en`.
- R5: A rising edge of `run_en` sets `cur_ch` and the target to `home_ch`, enters scan mode and clears all scan counters. While `run_en` is low, no pulse is produced.
- R6: A `sync_found` in scan mode with `lock_sel`=1 enters lock mode, where no pulse occurs and `cur_ch` does not change.
- R7: A `sync_found` in scan mode with `lock_sel`=0 enters normal mode, which keeps stepping as in R2.
- R8: `unsync` is 0 in lock and normal modes and 1 in scan and idle modes.
- R9: In a synced mode, after `sync_lost`, the block returns to scan mode with `unsync`=1 once hold_sel+1 ticks have been counted (hold_sel 0..3 selects 1..4 ticks).
- R10: A `sync_found` while the hold is running cancels it, and later ticks have no effect.
- R11: After MAX_SCANS complete scans (16 steps each) with no sync, the block enters idle, where no pulse occurs. After IDLE_TICKS ticks it resumes scanning.
- R12: After reset: `cur_ch` equals `home_ch`, `chg_pulse`=0 and `unsync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Operation enable; rising edge restarts at home |
| home_ch | input | 4 | Configured home channel |
| hold_sel | input | 2 | Sync-loss hold: hold_sel+1 ticks |
| lock_sel | input | 1 | 1 = lock mode, 0 = normal mode after sync |
| syn_win | input | 1 | Synthesizer-enable window, active high |
| sync_found | input | 1 | One-cycle synchronisation found indication |
| sync_lost | input | 1 | One-cycle synchronisation lost indication |
| tick | input | 1 | One-cycle slow timebase strobe |
| chg_pulse | output | 1 | One-cycle channel increment pulse |
| cur_ch | output | 4 | Current decoder channel |
| unsync | output | 1 | High when not synchronised |

## Verification
The scan walk is swept from every one of the sixteen home channels for several windows. This checks the order mapping, the wrap from channel 1 back to channel 0, and the rule that the channel updates only at the window edge rather than at the pulse. The hold time is swept over all four settings, counting ticks up to and past the limit, so that an off-by-one in the hold count is exposed. Lock and normal modes are each tried with the same window pattern, which separates "no stepping" from "stepping". A full run of failed scans and the idle wait shows whether the scan counting and the idle timing are correct.

// File: rtl/chan_scan_pkg.sv
// Shared types and the scan-order mapping for the channel scan sequencer.
// Assumes exactly sixteen channels addressed by a 4-bit code.
package chan_scan_pkg;

    typedef enum logic [1:0] {
        M_SCAN = 2'd0,
        M_IDLE = 2'd1,
        M_LOCK = 2'd2,
        M_NORM = 2'd3
    } scan_mode_t;

    // Position to channel: even channels rising, then odd channels falling.
    function automatic logic [3:0] pos_to_ch(input logic [3:0] p);
        return {p[2:0] ^ {3{p[3]}}, p[3]};
    endfunction

    // Channel to position: inverse of pos_to_ch.
    function automatic logic [3:0] ch_to_pos(input logic [3:0] c);
        return {c[0], c[3:1] ^ {3{c[0]}}};
    endfunction

endpackage

// File: rtl/csq_tick_timer.sv
// Counts slow-timebase ticks while running and reports when a limit is reached.
// Assumes limit >= 1. The count holds at the limit until it is cleared.
module csq_tick_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done_o
);
    logic [W-1:0] cnt;

    assign done_o = (cnt == limit);

    // Tick counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run && tick && !done_o) begin
            cnt <= cnt + W'(1);
        end
    end

    // R9
    timer_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr) |=> done_o);
endmodule

// File: rtl/csq_stepper.sv
// Dwell counter and scan-position tracker. While stepping is enabled and the
// window is open, every DWELL_CYC window cycles it advances the target
// position and raises a one-cycle pulse. The current position takes the
// target at the window's rising edge. Assumes DWELL_CYC >= 2.
module csq_stepper #(
    parameter int DWELL_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [3:0] home_pos,
    input  logic       win,
    input  logic       step_en,
    output logic       chg_o,
    output logic [3:0] cur_pos_o
);
    localparam int DW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DWELL_CYC - 1);

    logic          win_q;
    logic [DW-1:0] dwell;
    logic [3:0]    tgt;
    logic          win_rise;

    assign win_rise = win && !win_q;

    // Window edge detect, dwell timing, target stepping and channel update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= 1'b0;
            dwell     <= '0;
            tgt       <= home_pos;
            cur_pos_o <= home_pos;
            chg_o     <= 1'b0;
        end else begin
            win_q <= win;
            chg_o <= 1'b0;
            if (clr) begin
                dwell     <= '0;
                tgt       <= home_pos;
                cur_pos_o <= home_pos;
            end else begin
                if (win_rise) begin
                    cur_pos_o <= tgt;
                end
                if (win && step_en) begin
                    if (dwell == DLAST) begin
                        dwell <= '0;
                        tgt   <= tgt + 4'd1;
                        chg_o <= 1'b1;
                    end else begin
                        dwell <= dwell + DW'(1);
                    end
                end else begin
                    dwell <= '0;
                end
            end
        end
    end

    // R3
    pulse_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |-> $past(win));
    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> !chg_o);
    // R4
    chan_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(win_rise) && !$past(clr)) |-> $stable(cur_pos_o));
endmodule

// File: rtl/chan_scan_seq.sv
// Channel scan sequencer top. Holds the operating mode (scan, idle, lock,
// normal), counts failed full scans, runs the sync-loss hold and idle timers,
// and drives the synchronised indicator. Assumes sync_found, sync_lost and
// tick are one-cycle strobes synchronous to clk.
module chan_scan_seq #(
    parameter int DWELL_CYC  = 8,
    parameter int MAX_SCANS  = 3,
    parameter int IDLE_TICKS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [3:0] home_ch,
    input  logic [1:0] hold_sel,
    input  logic       lock_sel,
    input  logic       syn_win,
    input  logic       sync_found,
    input  logic       sync_lost,
    input  logic       tick,
    output logic       chg_pulse,
    output logic [3:0] cur_ch,
    output logic       unsync
);
    import chan_scan_pkg::*;

    localparam int SW = (MAX_SCANS > 1) ? $clog2(MAX_SCANS) : 1;
    localparam int IW = $clog2(IDLE_TICKS + 1);
    localparam logic [SW-1:0] SLAST = SW'(MAX_SCANS - 1);

    scan_mode_t  mode;
    logic        run_q;
    logic        run_rise;
    logic        lost_q;
    logic [3:0]  step_cnt;
    logic [SW-1:0] scan_cnt;
    logic        hold_done;
    logic        idle_done;
    logic        synced;
    logic [3:0]  cur_pos;
    logic [2:0]  hold_lim;

    assign run_rise = run_en && !run_q;
    assign synced   = (mode == M_LOCK) || (mode == M_NORM);
    assign unsync   = !synced;
    assign hold_lim = {1'b0, hold_sel} + 3'd1;
    assign cur_ch   = pos_to_ch(cur_pos);

    csq_stepper #(.DWELL_CYC(DWELL_CYC)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (run_rise),
        .home_pos  (ch_to_pos(home_ch)),
        .win       (syn_win),
        .step_en   (run_en && (mode == M_SCAN || mode == M_NORM)),
        .chg_o     (chg_pulse),
        .cur_pos_o (cur_pos)
    );

    csq_tick_timer #(.W(3)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!(synced && lost_q)),
        .run    (1'b1),
        .tick   (tick),
        .limit  (hold_lim),
        .done_o (hold_done)
    );

    csq_tick_timer #(.W(IW)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mode != M_IDLE),
        .run    (1'b1),
        .tick   (tick),
        .limit  (IW'(IDLE_TICKS)),
        .done_o (idle_done)
    );

    // Mode sequencing, failed-scan counting and the sync-loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= M_SCAN;
            run_q    <= 1'b0;
            lost_q   <= 1'b0;
            step_cnt <= '0;
            scan_cnt <= '0;
        end else begin
            run_q <= run_en;
            if (run_rise) begin
                mode     <= M_SCAN;
                lost_q   <= 1'b0;
                step_cnt <= '0;
                scan_cnt <= '0;
            end else begin
                case (mode)
                    M_SCAN: begin
                        if (sync_found) begin
                            mode     <= lock_sel ? M_LOCK : M_NORM;
                            step_cnt <= '0;
                            scan_cnt <= '0;
                        end else if (chg_pulse) begin
                            step_cnt <= step_cnt + 4'd1;
                            if (step_cnt == 4'd15) begin
                                if (scan_cnt == SLAST) begin
                                    mode     <= M_IDLE;
                                    scan_cnt <= '0;
                                end else begin
                                    scan_cnt <= scan_cnt + SW'(1);
                                end
                            end
                        end
                    end
                    M_IDLE: begin
                        if (idle_done) mode <= M_SCAN;
                    end
                    default: begin
                        if (hold_done) begin
                            mode   <= M_SCAN;
                            lost_q <= 1'b0;
                        end else if (sync_found) begin
                            lost_q <= 1'b0;
                        end else if (sync_lost) begin
                            lost_q <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R6
    lock_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOCK && $past(mode) == M_LOCK) |-> !chg_pulse);
    // R11
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE && $past(mode) == M_IDLE) |-> !chg_pulse);
    // R9
    synced_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(synced) && mode == M_SCAN) |-> ($past(hold_done) || $past(run_rise)));
    // R8
    unsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unsync) |-> ($past(hold_done) || $past(run_rise)));
endmodule

// File: tb/chan_scan_seq_test.sv
module chan_scan_seq_test;
    localparam int DW = 4;
    localparam int NSCAN = 2;
    localparam int NIDLE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [3:0] home_ch = 4'd5;
    logic [1:0] hold_sel = 2'd0;
    logic lock_sel = 1'b1;
    logic syn_win = 1'b0;
    logic sync_found = 1'b0;
    logic sync_lost = 1'b0;
    logic tick = 1'b0;
    logic chg_pulse;
    logic [3:0] cur_ch;
    logic unsync;

    int checks = 0;
    int fails = 0;
    int pcount = 0;

    always #10 clk = ~clk;

    chan_scan_seq #(.DWELL_CYC(DW), .MAX_SCANS(NSCAN), .IDLE_TICKS(NIDLE)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .home_ch(home_ch),
        .hold_sel(hold_sel), .lock_sel(lock_sel), .syn_win(syn_win),
        .sync_found(sync_found), .sync_lost(sync_lost), .tick(tick),
        .chg_pulse(chg_pulse), .cur_ch(cur_ch), .unsync(unsync)
    );

    always @(negedge clk) if (chg_pulse === 1'b1) pcount++;

    function automatic int ord(input int p);
        int q = p % 16;
        return (q < 8) ? 2 * q : 31 - 2 * q;
    endfunction

    function automatic int pos_of(input int ch);
        for (int p = 0; p < 16; p++) if (ord(p) == ch) return p;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input int h);
        @(negedge clk) run_en = 1'b0; home_ch = 4'(h);
        repeat (2) @(negedge clk);
        run_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic win_open();
        @(negedge clk) syn_win = 1'b1;
        repeat (DW + 1) @(negedge clk);
    endtask

    task automatic win_close();
        syn_win = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe_found();
        @(negedge clk) sync_found = 1'b1;
        @(negedge clk) sync_found = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int base;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(cur_ch == 4'd5, "R12 cur_ch", cur_ch, 5);
        chk(chg_pulse == 1'b0, "R12 chg_pulse", chg_pulse, 0);
        chk(unsync == 1'b1, "R12 unsync", unsync, 1);

        // R3: no pulses with window closed
        restart(5);
        base = pcount;
        repeat (40) @(negedge clk);
        chk(pcount == base, "R3 window low", pcount - base, 0);

        // R1 R2 R4 R5: sweep every home channel
        for (int h = 0; h < 16; h++) begin
            restart(h);
            chk(cur_ch == 4'(h), "R5 home restart", cur_ch, h);
            p0 = pos_of(h);
            for (int j = 0; j < 4; j++) begin
                base = pcount;
                win_open();
                chk(cur_ch == 4'(ord(p0 + j)), "R1 scan order", cur_ch, ord(p0 + j));
                win_close();
                chk(pcount == base + 1, "R2 one pulse per step", pcount - base, 1);
                chk(cur_ch == 4'(ord(p0 + j)), "R4 update at window edge", cur_ch, ord(p0 + j));
            end
        end

        // R5: run_en low blocks pulses
        @(negedge clk) run_en = 1'b0;
        base = pcount;
        win_open();
        win_close();
        chk(pcount == base, "R5 disabled no pulse", pcount - base, 0);

        // R6 R8: lock mode
        restart(3);
        lock_sel = 1'b1;
        strobe_found();
        chk(unsync == 1'b0, "R8 synced low", unsync, 0);
        base = pcount;
        for (int j = 0; j < 3; j++) begin
            win_open();
            win_close();
        end
        chk(pcount == base, "R6 lock no pulse", pcount - base, 0);
        chk(cur_ch == 4'd3, "R6 lock channel", cur_ch, 3);

        // R9: hold sweep
        for (int s = 0; s < 4; s++) begin
            restart(6);
            lock_sel = 1'b1;
            hold_sel = 2'(s);
            strobe_found();
            @(negedge clk) sync_lost = 1'b1;
            @(negedge clk) sync_lost = 1'b0;
            for (int t = 0; t < s; t++) strobe_tick();
            chk(unsync == 1'b0, "R9 before hold expiry", unsync, 0);
            strobe_tick();
            repeat (2) @(negedge clk);
            chk(unsync == 1'b1, "R9 after hold expiry", unsync, 1);
            base = pcount;
            win_open();
            win_close();
            chk(pcount == base + 1, "R9 scanning resumed", pcount - base, 1);
        end

        // R10: found during hold cancels it
        restart(6);
        hold_sel = 2'd0;
        strobe_found();
        @(negedge clk) sync_lost = 1'b1;
        @(negedge clk) sync_lost = 1'b0;
        strobe_found();
        for (int t = 0; t < 3; t++) strobe_tick();
        repeat (2) @(negedge clk);
        chk(unsync == 1'b0, "R10 hold cancelled", unsync, 0);

        // R7: normal mode keeps stepping
        restart(4);
        lock_sel = 1'b0;
        strobe_found();
        chk(unsync == 1'b0, "R8 normal synced", unsync, 0);
        base = pcount;
        win_open();
        win_close();
        win_open();
        chk(cur_ch == 4'(ord(pos_of(4) + 1)), "R7 normal channel", cur_ch, ord(pos_of(4) + 1));
        win_close();
        chk(pcount == base + 2, "R7 normal pulses", pcount - base, 2);

        // R11: failed scans lead to idle, then timed return
        restart(0);
        base = pcount;
        for (int j = 0; j < 16 * NSCAN; j++) begin
            win_open();
            win_close();
        end
        chk(pcount == base + 16 * NSCAN, "R11 full scans", pcount - base, 16 * NSCAN);
        chk(unsync == 1'b1, "R8 idle unsynced", unsync, 1);
        base = pcount;
        win_open();
        win_close();
        chk(pcount == base, "R11 idle no pulse", pcount - base, 0);
        for (int t = 0; t < NIDLE - 1; t++) strobe_tick();
        win_open();
        win_close();
        chk(pcount == base, "R11 idle before expiry", pcount - base, 0);
        strobe_tick();
        repeat (2) @(negedge clk);
        win_open();
        win_close();
        chk(pcount == base + 1, "R11 scan after idle", pcount - base, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule